// File: doc/BRIEF.md
# I2C Byte-Lane Word Packer

This block sits between a host that moves 32-bit data words and a byte-serial I2C bit engine. It does not generate bus timing and does not decode registers. Both of those live in neighbouring blocks.

In the transmit direction the host pushes words into a small transmit FIFO. A phase is then started with a byte count. The engine pulls bytes one at a time, starting with the least significant byte lane of each word. The first byte of a message carries the target address and the direction bit, so it sits in the low lane of the first word. When the count runs out partway through a word, the unused upper lanes of that word are dropped.

In the receive direction the engine delivers bytes, and the block gathers them into words starting at the low lane. Each complete word goes into a receive FIFO. A partial word is pushed with zeroed upper lanes when the phase count reaches zero. The host polls the receive-queue-empty status before reading each word.

Top module: `i2c_word_lane_packer`

## Requirements
- R1: After reset, `tx_empty` and `rx_empty` are 1, `tx_full`, `rx_full`, `busy`, `tx_overflow` and `rx_underflow` are 0, and `tx_byte_vld` is 0.
- R2: During a transmit phase the bytes of each word are offered in the order bits 7:0, 15:8, 23:16, 31:24, and the words are offered in the order they were written.
- R3: The first byte of a transmit phase is bits 7:0 of the oldest word, which holds the 7-bit target address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read).
- R4: A transmit phase offers exactly `start_len` bytes. If it ends before lane 3 of a word, that word is removed and its remaining lanes are never offered.
- R5: `tx_byte_vld` is 1 only while a transmit phase is active and the transmit FIFO holds a word.
- R6: During a receive phase, accepted bytes fill a word from bits 7:0 upward. After every fourth byte the word is pushed into the receive FIFO.
- R7: When a receive phase ends with 1 to 3 bytes collected, that partial word is pushed with its unused upper lanes set to zero.
- R8: `rx_empty` is 1 exactly when the receive FIFO holds no word. `rx_rd_data` shows the oldest word, and `rx_rd_en` removes it, so words leave in arrival order.
- R9: A host write while `tx_full` is 1 is ignored and sets `tx_overflow`, which then stays 1 until reset.
- R10: A host read while `rx_empty` is 1 is ignored and sets `rx_underflow`, which then stays 1 until reset.
- R11: `tx_full` / `rx_full` are 1 when the FIFO holds its depth in words, and `tx_empty` / `rx_empty` are 1 when it holds none.
- R12: `start` is accepted only while `busy` is 0 and `start_len` is nonzero. `busy` stays 1 until the phase has moved `start_len` bytes.
- R13: `rx_byte_rdy` is 0 whenever the receive FIFO is full, so no byte is lost. Bytes resume once the host frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_wr_en | input | 1 | Host writes a transmit word |
| tx_wr_data | input | 32 | Transmit word |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_overflow | output | 1 | Sticky: write attempted while full |
| rx_rd_en | input | 1 | Host reads a receive word |
| rx_rd_data | output | 32 | Oldest receive word |
| rx_empty | output | 1 | Receive-queue-empty status |
| rx_full | output | 1 | Receive FIFO full |
| rx_underflow | output | 1 | Sticky: read attempted while empty |
| start | input | 1 | Start a phase |
| start_len | input | LEN_W | Byte count of the phase |
| start_rx | input | 1 | 1 = receive phase, 0 = transmit phase |
| busy | output | 1 | Phase in progress |
| tx_byte_vld | output | 1 | Transmit byte available to the engine |
| tx_byte | output | 8 | Current transmit byte |
| tx_byte_take | input | 1 | Engine consumes the transmit byte |
| rx_byte_vld | input | 1 | Engine delivers a received byte |
| rx_byte_in | input | 8 | Received byte |
| rx_byte_rdy | output | 1 | Block can accept a received byte |

## Verification
The properties assume that the engine asserts `tx_byte_take` only as a response to `tx_byte_vld`, and that it treats `rx_byte_vld` as a handshake that counts only when `rx_byte_rdy` is high. The bench engine model follows both rules. It first checks the matching ready or valid output, and only then pulses the take or valid input for a single cycle.

The FIFO depths are assumed to be at least two. The bench uses the default depth of four so that it can fill and overflow the FIFOs.

// File: rtl/i2c_word_lane_packer.sv
module i2c_word_lane_packer #(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int LEN_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_wr_en,
  input  logic [31:0]      tx_wr_data,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             tx_overflow,
  input  logic             rx_rd_en,
  output logic [31:0]      rx_rd_data,
  output logic             rx_empty,
  output logic             rx_full,
  output logic             rx_underflow,
  input  logic             start,
  input  logic [LEN_W-1:0] start_len,
  input  logic             start_rx,
  output logic             busy,
  output logic             tx_byte_vld,
  output logic [7:0]       tx_byte,
  input  logic             tx_byte_take,
  input  logic             rx_byte_vld,
  input  logic [7:0]       rx_byte_in,
  output logic             rx_byte_rdy
);
  localparam int TXA = $clog2(TX_DEPTH);
  localparam int RXA = $clog2(RX_DEPTH);
  localparam logic [TXA-1:0] TX_LAST = TXA'(TX_DEPTH - 1);
  localparam logic [RXA-1:0] RX_LAST = RXA'(RX_DEPTH - 1);
  localparam logic [TXA:0]   TX_FULLV = (TXA+1)'(TX_DEPTH);
  localparam logic [RXA:0]   RX_FULLV = (RXA+1)'(RX_DEPTH);

  logic [31:0]      tx_mem [TX_DEPTH];
  logic [31:0]      rx_mem [RX_DEPTH];
  logic [TXA-1:0]   tx_wp, tx_rp;
  logic [RXA-1:0]   rx_wp, rx_rp;
  logic [TXA:0]     tx_cnt;
  logic [RXA:0]     rx_cnt;
  logic [LEN_W-1:0] rem;
  logic             rx_mode;
  logic [1:0]       lane;
  logic [31:0]      acc, acc_next;

  assign tx_full  = (tx_cnt == TX_FULLV);
  assign tx_empty = (tx_cnt == '0);
  assign rx_full  = (rx_cnt == RX_FULLV);
  assign rx_empty = (rx_cnt == '0);
  assign busy     = (rem != '0);

  wire [31:0] tx_head = tx_mem[tx_rp];
  assign tx_byte     = tx_head[{lane, 3'b000} +: 8];
  assign tx_byte_vld = busy && !rx_mode && !tx_empty;
  assign rx_byte_rdy = busy && rx_mode && !rx_full;
  assign rx_rd_data  = rx_mem[rx_rp];

  wire last_of_word = (lane == 2'd3) || (rem == LEN_W'(1));
  wire tx_step  = tx_byte_vld && tx_byte_take;
  wire rx_step  = rx_byte_rdy && rx_byte_vld;
  wire tx_push  = tx_wr_en && !tx_full;
  wire tx_pop   = tx_step && last_of_word;
  wire rx_push  = rx_step && last_of_word;
  wire rx_pop   = rx_rd_en && !rx_empty;
  wire start_ok = start && !busy && (start_len != '0);

  assign acc_next = acc | ({24'b0, rx_byte_in} << {lane, 3'b000});

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= tx_wr_data;
    if (rx_push) rx_mem[rx_wp] <= acc_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      tx_overflow <= 1'b0; rx_underflow <= 1'b0;
    end else begin
      if (tx_wr_en && tx_full) tx_overflow <= 1'b1;
      if (rx_rd_en && rx_empty) rx_underflow <= 1'b1;
      if (tx_push) tx_wp <= (tx_wp == TX_LAST) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == TX_LAST) ? '0 : tx_rp + 1'b1;
      if (rx_push) rx_wp <= (rx_wp == RX_LAST) ? '0 : rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= (rx_rp == RX_LAST) ? '0 : rx_rp + 1'b1;
      case ({tx_push, tx_pop})
        2'b10:   tx_cnt <= tx_cnt + 1'b1;
        2'b01:   tx_cnt <= tx_cnt - 1'b1;
        default: tx_cnt <= tx_cnt;
      endcase
      case ({rx_push, rx_pop})
        2'b10:   rx_cnt <= rx_cnt + 1'b1;
        2'b01:   rx_cnt <= rx_cnt - 1'b1;
        default: rx_cnt <= rx_cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0; rx_mode <= 1'b0; lane <= '0; acc <= '0;
    end else if (start_ok) begin
      rem <= start_len; rx_mode <= start_rx; lane <= '0; acc <= '0;
    end else if (tx_step || rx_step) begin
      rem  <= rem - 1'b1;
      lane <= last_of_word ? 2'd0 : lane + 1'b1;
      acc  <= (rx_step && !last_of_word) ? acc_next : '0;
    end
  end
endmodule

module i2c_word_lane_packer_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_wr_en,
  input logic tx_full,
  input logic tx_empty,
  input logic tx_overflow,
  input logic rx_rd_en,
  input logic rx_empty,
  input logic rx_full,
  input logic rx_underflow,
  input logic busy,
  input logic tx_byte_vld,
  input logic tx_byte_take,
  input logic rx_byte_vld,
  input logic rx_byte_rdy
);
  p_tx_flags_r11: assert property (@(posedge clk) disable iff (!rst_n) !(tx_full && tx_empty));
  p_rx_flags_r11: assert property (@(posedge clk) disable iff (!rst_n) !(rx_full && rx_empty));
  p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n) tx_wr_en && tx_full |=> tx_overflow);
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n) tx_overflow |=> tx_overflow);
  p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && !(tx_byte_vld && tx_byte_take) |=> tx_full);
  p_udf_set_r10: assert property (@(posedge clk) disable iff (!rst_n) rx_rd_en && rx_empty |=> rx_underflow);
  p_udf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n) rx_underflow |=> rx_underflow);
  p_vld_needs_word_r5: assert property (@(posedge clk) disable iff (!rst_n) tx_byte_vld |-> busy && !tx_empty);
  p_rdy_needs_room_r13: assert property (@(posedge clk) disable iff (!rst_n) rx_byte_rdy |-> busy && !rx_full);
  p_empty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty && !(rx_byte_vld && rx_byte_rdy) |=> rx_empty);
  p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(tx_byte_vld && tx_byte_take) && !(rx_byte_vld && rx_byte_rdy) |=> busy);
endmodule

bind i2c_word_lane_packer i2c_word_lane_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr_en(tx_wr_en), .tx_full(tx_full), .tx_empty(tx_empty),
  .tx_overflow(tx_overflow), .rx_rd_en(rx_rd_en), .rx_empty(rx_empty), .rx_full(rx_full),
  .rx_underflow(rx_underflow), .busy(busy), .tx_byte_vld(tx_byte_vld),
  .tx_byte_take(tx_byte_take), .rx_byte_vld(rx_byte_vld), .rx_byte_rdy(rx_byte_rdy)
);

// File: tb/i2c_word_lane_packer_test.sv
`timescale 1ns/1ps
module i2c_word_lane_packer_test;
  logic clk = 0, rst_n = 0;
  logic tx_wr_en = 0, rx_rd_en = 0, start = 0, start_rx = 0;
  logic tx_byte_take = 0, rx_byte_vld = 0;
  logic [31:0] tx_wr_data = 0;
  logic [15:0] start_len = 0;
  logic [7:0] rx_byte_in = 0;
  logic tx_full, tx_empty, tx_overflow, rx_empty, rx_full, rx_underflow, busy;
  logic tx_byte_vld, rx_byte_rdy;
  logic [7:0] tx_byte;
  logic [31:0] rx_rd_data;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  i2c_word_lane_packer uut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_tx(input logic [31:0] w);
    tx_wr_en = 1; tx_wr_data = w; @(negedge clk); tx_wr_en = 0;
  endtask

  task automatic begin_phase(input logic [15:0] len, input bit rx);
    start = 1; start_len = len; start_rx = rx; @(negedge clk); start = 0;
  endtask

  task automatic take_byte(input logic [7:0] exp, input string req);
    check(tx_byte_vld === 1'b1, req, {31'b0, tx_byte_vld}, 32'd1);
    check(tx_byte === exp, req, {24'b0, tx_byte}, {24'b0, exp});
    tx_byte_take = 1; @(negedge clk); tx_byte_take = 0;
  endtask

  task automatic give_byte(input logic [7:0] b);
    check(rx_byte_rdy === 1'b1, "R13", {31'b0, rx_byte_rdy}, 32'd1);
    rx_byte_vld = 1; rx_byte_in = b; @(negedge clk); rx_byte_vld = 0;
  endtask

  task automatic read_word(input logic [31:0] exp, input string req);
    check(rx_empty === 1'b0, "R8", {31'b0, rx_empty}, 32'd0);
    check(rx_rd_data === exp, req, rx_rd_data, exp);
    rx_rd_en = 1; @(negedge clk); rx_rd_en = 0;
  endtask

  task automatic t_reset;
    check(tx_empty === 1 && rx_empty === 1, "R1", {30'b0, tx_empty, rx_empty}, 32'd3);
    check(tx_full === 0 && rx_full === 0 && busy === 0, "R1", {29'b0, tx_full, rx_full, busy}, 0);
    check(tx_overflow === 0 && rx_underflow === 0 && tx_byte_vld === 0, "R1",
          {29'b0, tx_overflow, rx_underflow, tx_byte_vld}, 0);
  endtask

  task automatic t_tx_write_addr;
    push_tx(32'h332211A0);
    check(tx_byte_vld === 0, "R5", {31'b0, tx_byte_vld}, 0);
    begin_phase(4, 0);
    take_byte(8'hA0, "R3");
    take_byte(8'h11, "R2"); take_byte(8'h22, "R2"); take_byte(8'h33, "R2");
    check(busy === 0 && tx_empty === 1, "R4", {30'b0, busy, tx_empty}, 1);
  endtask

  task automatic t_tx_read_addr;
    push_tx(32'hFFFFFFA1);
    begin_phase(1, 0);
    take_byte(8'hA1, "R3");
    check(tx_empty === 1 && busy === 0, "R4", {30'b0, tx_empty, busy}, 1);
  endtask

  task automatic t_tx_partial;
    push_tx(32'hDDCCBBAA); push_tx(32'h11223344);
    begin_phase(6, 0);
    take_byte(8'hAA, "R2"); take_byte(8'hBB, "R2"); take_byte(8'hCC, "R2"); take_byte(8'hDD, "R2");
    take_byte(8'h44, "R4"); take_byte(8'h33, "R4");
    check(tx_empty === 1, "R4", {31'b0, tx_empty}, 1);
    check(tx_byte_vld === 0, "R5", {31'b0, tx_byte_vld}, 0);
  endtask

  task automatic t_tx_overflow;
    for (int i = 0; i < 4; i++) push_tx(32'h01010101 * (i + 1));
    check(tx_full === 1, "R11", {31'b0, tx_full}, 1);
    check(tx_overflow === 0, "R9", {31'b0, tx_overflow}, 0);
    push_tx(32'hDEADBEEF);
    check(tx_overflow === 1, "R9", {31'b0, tx_overflow}, 1);
    begin_phase(16, 0);
    for (int i = 0; i < 16; i++) take_byte(8'((i / 4) + 1), "R9");
    check(tx_empty === 1 && tx_overflow === 1, "R9", {30'b0, tx_empty, tx_overflow}, 3);
  endtask

  task automatic t_rx_basic;
    begin_phase(6, 1);
    check(tx_byte_vld === 0, "R5", {31'b0, tx_byte_vld}, 0);
    for (int i = 1; i <= 4; i++) give_byte(8'(i));
    check(rx_empty === 0, "R6", {31'b0, rx_empty}, 0);
    give_byte(8'h05); give_byte(8'h06);
    check(busy === 0, "R12", {31'b0, busy}, 0);
    read_word(32'h04030201, "R6");
    read_word(32'h00000605, "R7");
    check(rx_empty === 1, "R8", {31'b0, rx_empty}, 1);
  endtask

  task automatic t_rx_single;
    begin_phase(1, 1);
    give_byte(8'hC3);
    read_word(32'h000000C3, "R7");
  endtask

  task automatic t_rx_underflow;
    check(rx_underflow === 0, "R10", {31'b0, rx_underflow}, 0);
    rx_rd_en = 1; @(negedge clk); rx_rd_en = 0;
    check(rx_underflow === 1 && rx_empty === 1, "R10", {30'b0, rx_underflow, rx_empty}, 3);
    begin_phase(2, 1);
    give_byte(8'h5A); give_byte(8'hA5);
    read_word(32'h0000A55A, "R10");
    check(rx_underflow === 1, "R10", {31'b0, rx_underflow}, 1);
  endtask

  task automatic t_rx_backpressure;
    begin_phase(18, 1);
    for (int i = 1; i <= 16; i++) give_byte(8'(i));
    check(rx_full === 1, "R11", {31'b0, rx_full}, 1);
    check(rx_byte_rdy === 0 && busy === 1, "R13", {30'b0, rx_byte_rdy, busy}, 1);
    read_word(32'h04030201, "R8");
    give_byte(8'h11); give_byte(8'h12);
    read_word(32'h08070605, "R8");
    read_word(32'h0C0B0A09, "R8");
    read_word(32'h100F0E0D, "R13");
    read_word(32'h00001211, "R7");
    check(rx_empty === 1, "R11", {31'b0, rx_empty}, 1);
  endtask

  task automatic t_start_rules;
    begin_phase(0, 0);
    check(busy === 0, "R12", {31'b0, busy}, 0);
    push_tx(32'h0D0C0B0A);
    begin_phase(2, 0);
    begin_phase(4, 1);
    check(busy === 1 && tx_byte_vld === 1, "R12", {30'b0, busy, tx_byte_vld}, 3);
    take_byte(8'h0A, "R12"); take_byte(8'h0B, "R12");
    check(busy === 0 && tx_empty === 1, "R12", {30'b0, busy, tx_empty}, 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_tx_write_addr;
    t_tx_read_addr;
    t_tx_partial;
    t_tx_overflow;
    t_rx_basic;
    t_rx_single;
    t_rx_backpressure;
    t_rx_underflow;
    t_start_rules;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule